// File: doc/BRIEF.md
# Variable-Width Call Depth Counter

This block tracks how deeply nested subroutine calls are, using a 7-bit depth field and a separate enable bit. It is meant to sit next to a processor status register and update both in a single cycle. The field is self-describing. A run of ones at its top, read from the most significant bit downward, acts as a width prefix. The bits below that prefix form the active counter. A long prefix gives a short counter, so software chooses how many call levels it may nest before a trap. The all-ones value switches counting off.

A call pulse moves the field up by one and a return pulse moves it down by one. Each counts only while the enable bit is set. If a call would carry out of the active counter, the field is left as it was and an overflow trap pulse is raised. If a return finds the active counter already at zero, the field is left as it was and an underflow trap pulse is raised. Every call sets the enable bit. A load port writes the field and the enable bit directly, for example when a saved status word is restored. The block raises the traps only. Branching to a handler is left to the core around it.

Top module: `call_depth_ctr`

## Requirements
- R1: While rst_ni is low, and until the first operation after it rises, field_o reads 0, en_o reads 0, and ovf_o and unf_o are low.
- R2: A cycle with load_i high commits load_field_i to field_o and load_en_i to en_o on the next clock edge. Any call_i or ret_i in that cycle is ignored, and no trap is raised.
- R3: A call with en_o set and field_o not all ones computes field_o+1. Let L be the number of leading ones of that new value, counted from bit 6 down. If any of its low 7-L bits is set, the new value is committed (e.g. 0x41 becomes 0x42, 0x3E becomes 0x3F).
- R4: On such a call, if the low 7-L bits of field_o+1 are all zero, field_o keeps its old value and ovf_o pulses high in the commit cycle (e.g. 0x3F, 0x6F and 0x7E each hold and trap).
- R5: A return with en_o set and field_o not all ones takes L from the current field_o. If any of its low 7-L bits is set, field_o is decremented by one (e.g. 0x41 becomes 0x40).
- R6: On such a return, if the low 7-L bits of field_o are all zero, field_o is unchanged and unf_o pulses high in the commit cycle (e.g. 0x40, 0x00 and 0x7E each hold and trap).
- R7: With field_o equal to 0x7F, calls and returns leave field_o unchanged and raise no trap.
- R8: With en_o clear, calls and returns leave field_o unchanged and raise no trap. A call sets en_o whatever its earlier value. A return leaves en_o unchanged.
- R9: ovf_o and unf_o are never high together. Each is high only in the cycle after a call or return that trapped, and is low after an idle cycle.
- R10: call_i and ret_i may be high in the same cycle only when load_i is also high; the load then wins as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call pulse (increment request) |
| ret_i | input | 1 | Return pulse (decrement request) |
| load_i | input | 1 | Direct write of field and enable |
| load_field_i | input | 7 | Field value to load |
| load_en_i | input | 1 | Enable value to load |
| field_o | output | 7 | Current depth field |
| en_o | output | 1 | Current enable bit |
| ovf_o | output | 1 | Overflow trap pulse |
| unf_o | output | 1 | Underflow trap pulse |

## Verification
The bench builds the block with its default 7-bit field. This makes every prefix length from zero to six reachable with single loads, together with the all-ones disable code. It places the field just below each counter boundary to hit overflow. The cases 0x3F, 0x6F and 0x7E cover a 6-bit, a 4-bit and a zero-bit counter. It also walks a chain of calls across the 0x3F/0x40 boundary, where the prefix length of the incremented value changes.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int unsigned FIELD_W = 7;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2
  } ccd_op_e;
endpackage

// File: rtl/ccd_prefix.sv
// Active-counter mask: ones below the leading-ones prefix of val_i.
module ccd_prefix #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mask_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] lead;

  always_comb begin
    logic run;
    lead = '0;
    run  = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (run && val_i[i]) lead = lead + CW'(1);
      else                 run  = 1'b0;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask_o[g] = (g < (W - int'(lead)));
  end
endmodule

// File: rtl/ccd_step.sv
module ccd_step
  import ccd_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] field_i,
  input  logic         en_i,
  input  ccd_op_e      op_i,
  output logic [W-1:0] field_o,
  output logic         en_o,
  output logic         ovf_o,
  output logic         unf_o
);
  logic [W-1:0] inc_val, dec_val, mask_inc, mask_cur;
  logic         active;

  assign inc_val = field_i + W'(1);
  assign dec_val = field_i - W'(1);
  assign active  = en_i && !(&field_i);

  // prefix of the incremented value bounds the increment
  ccd_prefix #(.W(W)) u_pfx_inc (.val_i(inc_val), .mask_o(mask_inc));
  // prefix of the current value bounds the decrement
  ccd_prefix #(.W(W)) u_pfx_cur (.val_i(field_i), .mask_o(mask_cur));

  always_comb begin
    field_o = field_i;
    en_o    = en_i;
    ovf_o   = 1'b0;
    unf_o   = 1'b0;
    unique case (op_i)
      OP_INC: begin
        en_o = 1'b1;
        if (active) begin
          if ((inc_val & mask_inc) == '0) ovf_o   = 1'b1;
          else                            field_o = inc_val;
        end
      end
      OP_DEC: begin
        if (active) begin
          if ((field_i & mask_cur) == '0) unf_o   = 1'b1;
          else                            field_o = dec_val;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    p_one_trap_r9: assert (!(ovf_o && unf_o));
  end
endmodule

// File: rtl/call_depth_ctr.sv
module call_depth_ctr
  import ccd_pkg::*;
#(
  parameter int unsigned W = ccd_pkg::FIELD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         call_i,
  input  logic         ret_i,
  input  logic         load_i,
  input  logic [W-1:0] load_field_i,
  input  logic         load_en_i,
  output logic [W-1:0] field_o,
  output logic         en_o,
  output logic         ovf_o,
  output logic         unf_o
);
  ccd_op_e      op;
  logic [W-1:0] field_q, field_d;
  logic         en_q, en_d, ovf_q, ovf_d, unf_q, unf_d;

  always_comb begin
    if (load_i)      op = OP_NONE;
    else if (call_i) op = OP_INC;
    else if (ret_i)  op = OP_DEC;
    else             op = OP_NONE;
  end

  ccd_step #(.W(W)) u_step (
    .field_i(field_q),
    .en_i   (en_q),
    .op_i   (op),
    .field_o(field_d),
    .en_o   (en_d),
    .ovf_o  (ovf_d),
    .unf_o  (unf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      en_q    <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else if (load_i) begin
      field_q <= load_field_i;
      en_q    <= load_en_i;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      field_q <= field_d;
      en_q    <= en_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  assign field_o = field_q;
  assign en_o    = en_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  p_call_ret_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(call_i && ret_i && !load_i));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (field_o == $past(load_field_i)) && (en_o == $past(load_en_i))
               && !ovf_o && !unf_o);

  p_ovf_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> field_o == $past(field_o));

  p_unf_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> field_o == $past(field_o));

  p_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&field_o && !load_i) |=> $stable(field_o) && !ovf_o && !unf_o);

  p_call_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !load_i) |=> en_o);

  p_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !load_i && !(call_i && ret_i)) |=> $stable(field_o) && !ovf_o && !unf_o);

  p_trap_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_i && !ret_i) |=> !ovf_o && !unf_o);
endmodule

// File: tb/tb_call_depth_ctr.sv
module tb_call_depth_ctr;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       call_i, ret_i, load_i, load_en_i;
  logic [6:0] load_field_i;
  logic [6:0] field_o;
  logic       en_o, ovf_o, unf_o;

  int tests = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  call_depth_ctr dut (
    .clk_i, .rst_ni, .call_i, .ret_i, .load_i,
    .load_field_i, .load_en_i, .field_o, .en_o, .ovf_o, .unf_o
  );

  task automatic check(string req, logic [6:0] ef, logic ee, logic eo, logic eu);
    tests++;
    if (field_o !== ef || en_o !== ee || ovf_o !== eo || unf_o !== eu) begin
      fails++;
      $display("FAIL %s: field=%h en=%b ovf=%b unf=%b expected field=%h en=%b ovf=%b unf=%b",
               req, field_o, en_o, ovf_o, unf_o, ef, ee, eo, eu);
    end
  endtask

  // drive on falling edge, commit on rising edge, sample 1 ns later
  task automatic cycle(logic c, logic r, logic l, logic [6:0] lf, logic le);
    @(negedge clk_i);
    call_i = c; ret_i = r; load_i = l; load_field_i = lf; load_en_i = le;
    @(posedge clk_i);
    #1;
    call_i = 0; ret_i = 0; load_i = 0;
  endtask

  task automatic load(logic [6:0] f, logic e);
    cycle(0, 0, 1, f, e);
  endtask

  task automatic t_reset;
    check("R1 reset", 7'h00, 0, 0, 0);
    cycle(0, 0, 0, 7'h00, 0);
    check("R1 idle after reset", 7'h00, 0, 0, 0);
  endtask

  task automatic t_load;
    load(7'h41, 1);
    check("R2 load", 7'h41, 1, 0, 0);
    cycle(1, 0, 1, 7'h22, 0);
    check("R2 load beats call", 7'h22, 0, 0, 0);
    load(7'h05, 1);
    cycle(1, 1, 1, 7'h33, 1);
    check("R10 call+ret with load", 7'h33, 1, 0, 0);
  endtask

  task automatic t_inc;
    load(7'h41, 1);
    cycle(1, 0, 0, 0, 0);
    check("R3 inc 41", 7'h42, 1, 0, 0);
    load(7'h3D, 1);
    cycle(1, 0, 0, 0, 0);
    check("R3 inc 3D", 7'h3E, 1, 0, 0);
    cycle(1, 0, 0, 0, 0);
    check("R3 inc 3E", 7'h3F, 1, 0, 0);
    cycle(1, 0, 0, 0, 0);
    check("R4 ovf chain 3F", 7'h3F, 1, 1, 0);
    cycle(0, 0, 0, 0, 0);
    check("R9 ovf drops", 7'h3F, 1, 0, 0);
  endtask

  task automatic t_ovf;
    load(7'h6F, 1);
    cycle(1, 0, 0, 0, 0);
    check("R4 ovf 6F", 7'h6F, 1, 1, 0);
    load(7'h7E, 1);
    cycle(1, 0, 0, 0, 0);
    check("R4 ovf 7E", 7'h7E, 1, 1, 0);
    cycle(1, 0, 0, 0, 0);
    check("R9 repeat ovf", 7'h7E, 1, 1, 0);
  endtask

  task automatic t_dec;
    load(7'h41, 1);
    cycle(0, 1, 0, 0, 0);
    check("R5 dec 41", 7'h40, 1, 0, 0);
    cycle(0, 1, 0, 0, 0);
    check("R6 unf 40", 7'h40, 1, 0, 1);
    cycle(0, 0, 0, 0, 0);
    check("R9 unf drops", 7'h40, 1, 0, 0);
    load(7'h00, 1);
    cycle(0, 1, 0, 0, 0);
    check("R6 unf 00", 7'h00, 1, 0, 1);
    load(7'h7E, 1);
    cycle(0, 1, 0, 0, 0);
    check("R6 unf 7E", 7'h7E, 1, 0, 1);
    load(7'h63, 1);
    cycle(0, 1, 0, 0, 0);
    check("R5 dec 63", 7'h62, 1, 0, 0);
  endtask

  task automatic t_disabled;
    load(7'h7F, 1);
    cycle(1, 0, 0, 0, 0);
    check("R7 call at 7F", 7'h7F, 1, 0, 0);
    cycle(0, 1, 0, 0, 0);
    check("R7 ret at 7F", 7'h7F, 1, 0, 0);
  endtask

  task automatic t_enable;
    load(7'h10, 0);
    cycle(0, 1, 0, 0, 0);
    check("R8 ret with en clear", 7'h10, 0, 0, 0);
    load(7'h00, 0);
    cycle(0, 1, 0, 0, 0);
    check("R8 no unf with en clear", 7'h00, 0, 0, 0);
    load(7'h05, 0);
    cycle(1, 0, 0, 0, 0);
    check("R8 call sets en, no count", 7'h05, 1, 0, 0);
    cycle(1, 0, 0, 0, 0);
    check("R8 counts once enabled", 7'h06, 1, 0, 0);
    load(7'h3F, 0);
    cycle(1, 0, 0, 0, 0);
    check("R8 no ovf with en clear", 7'h3F, 1, 0, 0);
  endtask

  initial begin
    rst_ni = 1'b0;
    call_i = 0; ret_i = 0; load_i = 0; load_field_i = '0; load_en_i = 0;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 in reset", 7'h00, 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_load();
    t_inc();
    t_ovf();
    t_dec();
    t_disabled();
    t_enable();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule